// File: doc/BRIEF.md
# Indirect Secondary-Bus Access Bridge

This block gives a host access to a secondary on-chip register bus without mapping that bus into the host's address space. The host first writes a data value into a write-data holding register. It then writes a command word that carries an operation code and a target address. The bridge runs exactly one request/acknowledge transaction on the secondary bus. It then publishes a result word that the host can read at any time. The result word packs a completion flag, a two-bit outcome code and sixteen bits of returned read data.

The secondary bus is a simple port. A request is held until the target either acknowledges it or raises an error, and the target's read data is taken in the acknowledge cycle. If the target never answers, an internal counter ends the transaction after `TIMEOUT_CYC` cycles and reports that no response arrived. The default is chosen well below the number of polls host software makes before it gives up. The outcome code distinguishes four cases: no response, success, a request the bridge refused to issue, and an error response from the target.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the result word `host_rd_word` is zero and `sb_req` is low.
- R2: `host_wr_sel` = 0 writes the command register and `host_wr_sel` = 1 writes the write-data register (bits [15:0]). A command word has its opcode in bits [31:28] and its address in bits [ADDR_W-1:0]. Opcode 1 drives a request with `sb_we` = 1, the command's address and the held write data. A completed write leaves result bits [15:0] at zero.
- R3: Opcode 2 drives a request with `sb_we` = 0. On acknowledge, `sb_rdata` appears in result bits [15:0].
- R4: Result bit 18 is the completion flag. It goes low in the cycle after a command is accepted and goes high in the cycle after the transaction ends. `sb_req` is never high while the flag is high.
- R5: Result bits [17:16] carry the outcome: 0 no response, 1 success, 2 request refused, 3 error response. An acknowledge without error gives code 1.
- R6: An opcode other than 1 or 2 issues no request. It completes in the next cycle with code 2.
- R7: A command with any nonzero bit between bit ADDR_W and bit 27 inclusive issues no request. It completes in the next cycle with code 2.
- R8: `sb_err` during a request ends it with code 3 and data field zero. This holds even when `sb_ack` is high in the same cycle.
- R9: A request that receives neither acknowledge nor error stays high for exactly `TIMEOUT_CYC` cycles. It then drops and the transaction completes with code 0.
- R10: While `sb_req` is high and unanswered, `sb_req`, `sb_we`, `sb_addr` and `sb_wdata` hold their values.
- R11: Host writes to either register while a transaction is in flight are ignored. They change neither the running request nor the write data used by the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_sel | input | 1 | 0 = command register, 1 = write-data register |
| host_wr_data | input | 32 | Host write value |
| host_rd_word | output | 32 | Result word: [18] done, [17:16] outcome, [15:0] read data |
| sb_req | output | 1 | Secondary bus request |
| sb_we | output | 1 | Secondary bus write (1) or read (0) |
| sb_addr | output | ADDR_W | Secondary bus address |
| sb_wdata | output | 16 | Secondary bus write data |
| sb_rdata | input | 16 | Secondary bus read data |
| sb_ack | input | 1 | Secondary bus acknowledge |
| sb_err | input | 1 | Secondary bus error response |

## Verification
A corrupted sequencer state shows up at the ports within a cycle or two. It appears as one of three symptoms: `sb_req` stays high alongside a set completion flag, the request drops with no result published, or a refused command still produces a request. A timeout counter that runs fast or slow changes how long an unanswered request stays high, so the bench counts those cycles exactly. A wrong holding register shows only on the next transaction. For that reason the bench issues a second write after attempting an in-flight overwrite of the write data.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int DATA_W    = 16;
  localparam int WORD_W    = 32;
  localparam int OPC_W     = 4;
  localparam int OPC_LSB   = 28;
  localparam int STAT_LSB  = 16;
  localparam int DONE_BIT  = 18;

  localparam logic [OPC_W-1:0] OPC_WRITE = 4'd1;
  localparam logic [OPC_W-1:0] OPC_READ  = 4'd2;

  typedef enum logic [1:0] {
    XS_NORESP  = 2'd0,
    XS_OK      = 2'd1,
    XS_REFUSED = 2'd2,
    XS_RSPERR  = 2'd3
  } xfer_status_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic valid;
    logic is_write;
  } opc_dec_t;
endpackage

// File: rtl/ibr_opc_decode.sv
module ibr_opc_decode
  import ibr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [WORD_W-1:ADDR_W] cmd_hi,
  output opc_dec_t               dec
);
  localparam int RSV_W = OPC_LSB - ADDR_W;

  logic [OPC_W-1:0] opc;
  logic [RSV_W-1:0] rsv;

  assign opc = cmd_hi[WORD_W-1:OPC_LSB];
  assign rsv = cmd_hi[OPC_LSB-1:ADDR_W];

  always_comb begin
    dec.valid    = 1'b0;
    dec.is_write = 1'b0;
    if (rsv == '0) begin
      if (opc == OPC_WRITE) begin
        dec.valid    = 1'b1;
        dec.is_write = 1'b1;
      end else if (opc == OPC_READ) begin
        dec.valid    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ibr_timeout.sv
module ibr_timeout #(
  parameter int LIMIT = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = run && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run && !expired) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
  import ibr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int TIMEOUT_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              wdat_wr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [DATA_W-1:0] sb_rdata,
  input  logic              sb_ack,
  input  logic              sb_err,
  output logic              sb_req,
  output logic              sb_we,
  output logic [ADDR_W-1:0] sb_addr,
  output logic [DATA_W-1:0] sb_wdata,
  output logic              done,
  output xfer_status_e      status,
  output logic [DATA_W-1:0] rdata
);
  seq_state_e        state_q, state_d;
  logic              done_q, done_d;
  xfer_status_e      stat_q, stat_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] wdat_q;
  logic              accept, wdat_en, expired;
  opc_dec_t          dec;

  ibr_opc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cmd_hi (wr_data[WORD_W-1:ADDR_W]),
    .dec    (dec)
  );

  ibr_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .run     (state_q == SEQ_BUSY),
    .expired (expired)
  );

  assign accept  = cmd_wr && (state_q == SEQ_IDLE);
  assign wdat_en = wdat_wr && (state_q == SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    stat_d  = stat_q;
    rdat_d  = rdat_q;
    addr_d  = addr_q;
    we_d    = we_q;
    if (state_q == SEQ_IDLE) begin
      if (accept) begin
        done_d = 1'b0;
        stat_d = XS_NORESP;
        rdat_d = '0;
        addr_d = wr_data[ADDR_W-1:0];
        we_d   = dec.is_write;
        if (dec.valid) begin
          state_d = SEQ_BUSY;
        end else begin
          done_d = 1'b1;
          stat_d = XS_REFUSED;
        end
      end
    end else begin
      if (sb_err) begin
        state_d = SEQ_IDLE;
        done_d  = 1'b1;
        stat_d  = XS_RSPERR;
        rdat_d  = '0;
      end else if (sb_ack) begin
        state_d = SEQ_IDLE;
        done_d  = 1'b1;
        stat_d  = XS_OK;
        rdat_d  = we_q ? '0 : sb_rdata;
      end else if (expired) begin
        state_d = SEQ_IDLE;
        done_d  = 1'b1;
        stat_d  = XS_NORESP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
      stat_q  <= XS_NORESP;
      rdat_q  <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      stat_q  <= stat_d;
      rdat_q  <= rdat_d;
      addr_q  <= addr_d;
      we_q    <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdat_q <= '0;
    else if (wdat_en) wdat_q <= wr_data[DATA_W-1:0];
  end

  assign sb_req   = (state_q == SEQ_BUSY);
  assign sb_we    = we_q;
  assign sb_addr  = addr_q;
  assign sb_wdata = wdat_q;
  assign done     = done_q;
  assign status   = stat_q;
  assign rdata    = rdat_q;
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int TIMEOUT_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_wr_sel,
  input  logic [31:0]       host_wr_data,
  output logic [31:0]       host_rd_word,
  output logic              sb_req,
  output logic              sb_we,
  output logic [ADDR_W-1:0] sb_addr,
  output logic [15:0]       sb_wdata,
  input  logic [15:0]       sb_rdata,
  input  logic              sb_ack,
  input  logic              sb_err
);
  localparam int PAD_W = WORD_W - DONE_BIT - 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              done;
  xfer_status_e      status;
  logic [DATA_W-1:0] rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ibr_seq #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd_wr   (host_wr_en && !host_wr_sel),
    .wdat_wr  (host_wr_en && host_wr_sel),
    .wr_data  (host_wr_data),
    .sb_rdata (sb_rdata),
    .sb_ack   (sb_ack),
    .sb_err   (sb_err),
    .sb_req   (sb_req),
    .sb_we    (sb_we),
    .sb_addr  (sb_addr),
    .sb_wdata (sb_wdata),
    .done     (done),
    .status   (status),
    .rdata    (rdata)
  );

  assign host_rd_word = {{PAD_W{1'b0}}, done, status, rdata};
endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk #(
  parameter int ADDR_W      = 12,
  parameter int TIMEOUT_CYC = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       host_rd_word,
  input logic              sb_req,
  input logic              sb_we,
  input logic [ADDR_W-1:0] sb_addr,
  input logic [15:0]       sb_wdata,
  input logic              sb_ack,
  input logic              sb_err
);
  localparam int RUN_W = $clog2(TIMEOUT_CYC + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (!sb_req)           run_q <= '0;
    else if (run_q <= RUN_W'(TIMEOUT_CYC)) run_q <= run_q + 1'b1;
  end

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_word[18] |-> !sb_req); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && !sb_ack && !sb_err) |=> (sb_req || host_rd_word[18])); // R10
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && !sb_ack && !sb_err) |=> (!sb_req || ($stable(sb_addr) && $stable(sb_we) && $stable(sb_wdata)))); // R10
  AST_ACK_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && sb_ack && !sb_err) |=> (host_rd_word[18] && host_rd_word[17:16] == 2'd1)); // R5
  AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && sb_err) |=> (host_rd_word[18] && host_rd_word[17:16] == 2'd3 && host_rd_word[15:0] == 16'h0)); // R8
  AST_REQ_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req |-> (run_q < RUN_W'(TIMEOUT_CYC))); // R9
endmodule

bind ibr_bridge ibr_bridge_chk #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_rd_word (host_rd_word),
  .sb_req       (sb_req),
  .sb_we        (sb_we),
  .sb_addr      (sb_addr),
  .sb_wdata     (sb_wdata),
  .sb_ack       (sb_ack),
  .sb_err       (sb_err)
);

// File: tb/sim_ibr_bridge.sv
module sim_ibr_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int TMO        = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              host_wr_en, host_wr_sel;
  logic [31:0]       host_wr_data, host_rd_word;
  logic              sb_req, sb_we, sb_ack, sb_err;
  logic [ADDR_W-1:0] sb_addr;
  logic [15:0]       sb_wdata, sb_rdata;
  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibr_bridge #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel),
    .host_wr_data(host_wr_data), .host_rd_word(host_rd_word), .sb_req(sb_req),
    .sb_we(sb_we), .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_rdata(sb_rdata),
    .sb_ack(sb_ack), .sb_err(sb_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_cmd(input logic [3:0] opc, input logic [11:0] addr, input logic [15:0] rsv);
    host_wr_en = 1'b1; host_wr_sel = 1'b0;
    host_wr_data = {opc, rsv[15:0], addr};
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_wdat(input logic [15:0] d);
    host_wr_en = 1'b1; host_wr_sel = 1'b1; host_wr_data = {16'h0, d};
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic respond(input int dly, input logic a, input logic e, input logic [15:0] d);
    repeat (dly) @(negedge clk);
    sb_ack = a; sb_err = e; sb_rdata = d;
    @(negedge clk);
    sb_ack = 1'b0; sb_err = 1'b0; sb_rdata = 16'h0;
  endtask

  task automatic t_reset();
    chk("R1 word", host_rd_word, 32'h0);
    chk("R1 req", {31'h0, sb_req}, 32'h0);
  endtask

  task automatic t_write();
    host_wdat(16'hBEEF);
    host_cmd(4'd1, 12'h012, 16'h0);
    chk("R2 req", {31'h0, sb_req}, 32'h1);
    chk("R2 we", {31'h0, sb_we}, 32'h1);
    chk("R2 addr", {20'h0, sb_addr}, 32'h012);
    chk("R2 wdata", {16'h0, sb_wdata}, 32'hBEEF);
    chk("R4 cleared", {31'h0, host_rd_word[18]}, 32'h0);
    respond(3, 1'b1, 1'b0, 16'h5A5A);
    chk("R5 R2 write ok", host_rd_word, 32'h0005_0000);
    chk("R4 req low", {31'h0, sb_req}, 32'h0);
  endtask

  task automatic t_read_busy();
    host_cmd(4'd2, 12'h034, 16'h0);
    chk("R3 we", {31'h0, sb_we}, 32'h0);
    host_cmd(4'd1, 12'h055, 16'h0);
    host_wdat(16'hAAAA);
    chk("R11 we", {31'h0, sb_we}, 32'h0);
    chk("R11 addr", {20'h0, sb_addr}, 32'h034);
    chk("R11 req", {31'h0, sb_req}, 32'h1);
    respond(1, 1'b1, 1'b0, 16'h1234);
    chk("R3 read data", host_rd_word, 32'h0005_1234);
    host_cmd(4'd1, 12'h0A0, 16'h0);
    chk("R11 wdata kept", {16'h0, sb_wdata}, 32'hBEEF);
    respond(0, 1'b1, 1'b0, 16'hFFFF);
    chk("R2 data zero", host_rd_word, 32'h0005_0000);
  endtask

  task automatic t_bad();
    host_cmd(4'd0, 12'h001, 16'h0);
    chk("R6 op0", host_rd_word, 32'h0006_0000);
    chk("R6 noreq", {31'h0, sb_req}, 32'h0);
    host_cmd(4'd7, 12'h001, 16'h0);
    chk("R6 op7", host_rd_word, 32'h0006_0000);
    host_cmd(4'd1, 12'h001, 16'h0100);
    chk("R7 rsv", host_rd_word, 32'h0006_0000);
    chk("R7 noreq", {31'h0, sb_req}, 32'h0);
  endtask

  task automatic t_err();
    host_cmd(4'd2, 12'h077, 16'h0);
    respond(2, 1'b0, 1'b1, 16'hFFFF);
    chk("R8 err", host_rd_word, 32'h0007_0000);
    host_cmd(4'd2, 12'h078, 16'h0);
    respond(0, 1'b1, 1'b1, 16'h4321);
    chk("R8 err wins", host_rd_word, 32'h0007_0000);
  endtask

  task automatic t_timeout();
    int n = 0;
    host_cmd(4'd2, 12'hFFF, 16'h0);
    while (sb_req && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk("R9 req cycles", n, TMO);
    chk("R9 noresp", host_rd_word, 32'h0004_0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr_en = 1'b0; host_wr_sel = 1'b0; host_wr_data = '0;
    sb_ack = 1'b0; sb_err = 1'b0; sb_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_read_busy();
    t_bad();
    t_err();
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule